// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block decides, for each of four transmit queues, whether the queue's gate is open and whether the frame at its head may start now. It follows a repeating schedule. A free-running time input in seconds plus nanoseconds is turned into one absolute nanosecond count and compared with an effective base time. Inside each cycle, every queue has an open window given by a start offset and an end offset. The queue's arbiter uses `may_send` to pick frames and `gate_open` to see the schedule state.

When the schedule is enabled and the configured base time is already behind the current time, the block moves the base forward to the first cycle boundary after the moment of enabling. It does this with a serial divider. While a nonzero base time is configured, the block runs in strict mode: a frame is admitted only if it ends no later than both the window end and the cycle end.

Configuration enters through a small write port. Writes go into shadow registers. While the schedule is running, the shadow values are copied into the live schedule at the next cycle boundary. In every other phase they are copied at once.

Top module: `txgate_sched`

## Requirements
- R1: While `tsn_en` is low, including straight after reset, every bit of `gate_open` and `may_send` is 1, whatever the frame lengths.
- R2: A falling `tsn_en` puts the cycle length back to 1,000,000,000 ns and every window back to start 0, end 1,000,000,000. A later enable with no window writes therefore leaves every gate open for the whole cycle.
- R3: From the rising edge of `tsn_en` until the absolute time reaches the effective base, all `gate_open` and `may_send` bits are 0.
- R4: If the configured base (seconds*1e9 + nanoseconds) is not earlier than the time captured at enable, it becomes the effective base unchanged, and windows open exactly when that time is reached.
- R5: If the configured base B is earlier than the captured time T, the effective base is B + (floor((T-B)/C)+1)*C, where C is the cycle length. This is the first boundary strictly after T.
- R6: With P = (now - effective base) mod cycle, queue q's gate is open exactly when start_q <= P < end_q and P < cycle. A window with start >= end never opens.
- R7: In strict mode (configured base nonzero), `may_send[q]` is 1 only when the gate is open, P + len_q <= end_q and P + len_q <= cycle. Here len_q is `head_len[16q+15:16q]` in ns.
- R8: With a configured base of zero, strict mode is off and `may_send` equals `gate_open` for any length.
- R9: Window or cycle writes made while the schedule is running do not change the outputs until the next cycle boundary, and apply from then on.
- R10: A write of zero to the cycle register is ignored. The previous cycle length stays in force.
- R11: Outputs are registered. A change of `now` is visible one clock later, and `may_send[q]` is never 1 while `gate_open[q]` is 0.
- R12: Register addresses are: 0 = cycle length, 1 = base nanoseconds, 2 = base seconds, 4+2q = start offset of queue q, 5+2q = end offset of queue q. Values sit in the low bits of `cfg_wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tsn_en | input | 1 | Schedule enable; low means gates bypassed and windows restored |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| now_sec | input | SEC_W | Current time, seconds |
| now_ns | input | NS_W | Current time, nanoseconds (0..999,999,999) |
| head_len | input | NQ*LEN_W | Per-queue head-frame duration in ns, queue q at bits [LEN_W*q +: LEN_W] |
| gate_open | output | NQ | Per-queue gate state |
| may_send | output | NQ | Per-queue permission to start the head frame |

## Verification
Most internal faults in this block change the timing of the output pattern rather than its shape. A wrong remainder in the divider or a wrong captured time shifts the whole window pattern by a constant offset. This shows up at the first gate edge after the effective base, within a few clocks of time reaching it. A cycle-start register that steps incorrectly moves every window edge after the first boundary. A commit at the wrong moment makes a queue open one cycle early or late, which shows up within the first position sampled after that boundary. Strict-fit errors appear only on `may_send`, and only for lengths that end exactly at, or one past, a window or cycle end, so those lengths are driven deliberately.

// File: rtl/txg_pkg.sv
package txg_pkg;
  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_ALIGN,
    PH_WAIT,
    PH_RUN
  } phase_e;
endpackage

// File: rtl/txg_cfg_regs.sv
module txg_cfg_regs #(
  parameter int unsigned NQ     = 4,
  parameter int unsigned NS_W   = 30,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tsn_en,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       commit,
  output logic [NS_W-1:0]            cyc_act,
  output logic [NQ-1:0][NS_W-1:0]    win_st,
  output logic [NQ-1:0][NS_W-1:0]    win_end,
  output logic [SEC_W-1:0]           base_sec,
  output logic [NS_W-1:0]            base_ns
);
  localparam logic [NS_W-1:0]   FULL     = NS_W'(txg_pkg::NS_PER_SEC);
  localparam logic [ADDR_W-1:0] A_CYC    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_BNS    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_BSEC   = ADDR_W'(2);
  localparam int unsigned       A_WIN0   = 4;

  logic            tsn_q;
  logic            dis_ev;
  logic [NS_W-1:0] cyc_sh;

  always_ff @(posedge clk) begin
    if (rst) tsn_q <= 1'b0;
    else     tsn_q <= tsn_en;
  end

  assign dis_ev = tsn_q & ~tsn_en;

  // cycle length: shadow and live copy; zero writes are dropped
  always_ff @(posedge clk) begin
    if (rst || dis_ev) begin
      cyc_sh <= FULL;
    end else if (wr_en && wr_addr == A_CYC && wr_data[NS_W-1:0] != '0) begin
      cyc_sh <= wr_data[NS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || dis_ev) cyc_act <= FULL;
    else if (commit)   cyc_act <= cyc_sh;
  end

  // base time is used only when the schedule is armed
  always_ff @(posedge clk) begin
    if (rst) begin
      base_sec <= '0;
      base_ns  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_BNS)  base_ns  <= wr_data[NS_W-1:0];
      if (wr_addr == A_BSEC) base_sec <= wr_data[SEC_W-1:0];
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_win
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(A_WIN0 + 2 * q);
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(A_WIN0 + 2 * q + 1);
    logic [NS_W-1:0] st_sh;
    logic [NS_W-1:0] en_sh;

    always_ff @(posedge clk) begin
      if (rst || dis_ev) begin
        st_sh <= '0;
        en_sh <= FULL;
      end else if (wr_en) begin
        if (wr_addr == A_ST) st_sh <= wr_data[NS_W-1:0];
        if (wr_addr == A_EN) en_sh <= wr_data[NS_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst || dis_ev) begin
        win_st[q]  <= '0;
        win_end[q] <= FULL;
      end else if (commit) begin
        win_st[q]  <= st_sh;
        win_end[q] <= en_sh;
      end
    end
  end

  // R10: the live cycle length never becomes zero
  a_r10_cycle_nonzero: assert property (@(posedge clk) disable iff (rst)
    cyc_act != '0);
endmodule

// File: rtl/txg_align_div.sv
module txg_align_div #(
  parameter int unsigned T_W = 63,
  parameter int unsigned C_W = 30
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [T_W-1:0] dividend,
  input  logic [C_W-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [C_W-1:0] rem
);
  localparam int unsigned CNT_W = $clog2(T_W + 1);

  logic [T_W-1:0]   shreg;
  logic [C_W-1:0]   d_q;
  logic [CNT_W-1:0] cnt;
  logic [C_W:0]     trial;

  assign trial = {rem, shreg[T_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      d_q   <= '0;
      cnt   <= '0;
      rem   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        shreg <= dividend;
        d_q   <= divisor;
        rem   <= '0;
        cnt   <= CNT_W'(T_W);
        busy  <= 1'b1;
      end else if (busy) begin
        if (trial >= {1'b0, d_q}) rem <= C_W'(trial - {1'b0, d_q});
        else                      rem <= trial[C_W-1:0];
        shreg <= shreg << 1;
        cnt   <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R5: the remainder that leaves the divider is below the divisor
  a_r5_rem_in_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem < d_q));
endmodule

// File: rtl/txg_cycle_track.sv
module txg_cycle_track #(
  parameter int unsigned T_W = 63,
  parameter int unsigned C_W = 30
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [T_W-1:0] load_time,
  input  logic           run,
  input  logic [T_W-1:0] now_abs,
  input  logic [C_W-1:0] cycle,
  output logic [T_W-1:0] pos,
  output logic           bnd
);
  logic [T_W-1:0] cyc_start;
  logic [T_W-1:0] elapsed;
  logic [T_W-1:0] cyc_x;

  assign cyc_x   = T_W'(cycle);
  assign elapsed = now_abs - cyc_start;
  assign bnd     = run && (elapsed >= cyc_x);
  assign pos     = bnd ? (elapsed - cyc_x) : elapsed;

  // steps one cycle per clock so large gaps are caught up gradually
  always_ff @(posedge clk) begin
    if (rst)       cyc_start <= '0;
    else if (load) cyc_start <= load_time;
    else if (bnd)  cyc_start <= cyc_start + cyc_x;
  end

  // R3: the running schedule never sits ahead of the time input
  a_r3_start_not_ahead: assert property (@(posedge clk) disable iff (rst)
    run |-> (now_abs >= cyc_start));
endmodule

// File: rtl/txg_gate_eval.sv
module txg_gate_eval #(
  parameter int unsigned T_W   = 63,
  parameter int unsigned NS_W  = 30,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic             active,
  input  logic             strict,
  input  logic [T_W-1:0]   pos,
  input  logic [NS_W-1:0]  cycle,
  input  logic [NS_W-1:0]  win_st,
  input  logic [NS_W-1:0]  win_end,
  input  logic [LEN_W-1:0] len,
  output logic             gate,
  output logic             may
);
  logic [T_W-1:0] st_x, en_x, cy_x, fin;
  logic           open_n, fit_n;

  always_comb begin
    st_x   = T_W'(win_st);
    en_x   = T_W'(win_end);
    cy_x   = T_W'(cycle);
    fin    = pos + T_W'(len);
    open_n = active && (pos < cy_x) && (pos >= st_x) && (pos < en_x);
    fit_n  = (fin <= en_x) && (fin <= cy_x);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate <= 1'b1;
      may  <= 1'b1;
    end else if (bypass) begin
      gate <= 1'b1;
      may  <= 1'b1;
    end else begin
      gate <= open_n;
      may  <= strict ? (open_n && fit_n) : open_n;
    end
  end

  // R11: permission to send only with an open gate
  a_r11_send_needs_gate: assert property (@(posedge clk) disable iff (rst)
    may |-> gate);
endmodule

// File: rtl/txgate_sched.sv
module txgate_sched #(
  parameter int unsigned NQ     = 4,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned NS_W   = 30,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = $clog2(4 + 2 * NQ)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tsn_en,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [31:0]           cfg_wdata,
  input  logic [SEC_W-1:0]      now_sec,
  input  logic [NS_W-1:0]       now_ns,
  input  logic [NQ*LEN_W-1:0]   head_len,
  output logic [NQ-1:0]         gate_open,
  output logic [NQ-1:0]         may_send
);
  import txg_pkg::*;

  localparam int unsigned T_W = SEC_W + NS_W + 1;
  localparam logic [T_W-1:0] SEC_SCALE = T_W'(NS_PER_SEC);

  phase_e                    ph;
  logic [NS_W-1:0]           cyc_act;
  logic [NQ-1:0][NS_W-1:0]   win_st, win_end;
  logic [SEC_W-1:0]          base_sec;
  logic [NS_W-1:0]           base_ns;
  logic [T_W-1:0]            now_abs, base_abs, cap_now, eff_base, pos;
  logic [NS_W-1:0]           cyc_cap, div_rem;
  logic                      strict_q, bnd, commit;
  logic                      div_start, div_busy, div_done;
  logic                      trk_load, running;

  assign now_abs  = T_W'(now_sec) * SEC_SCALE + T_W'(now_ns);
  assign base_abs = T_W'(base_sec) * SEC_SCALE + T_W'(base_ns);
  assign running  = tsn_en && (ph == PH_RUN);
  assign commit   = (ph != PH_RUN) || bnd;
  assign div_start = tsn_en && (ph == PH_OFF) && (now_abs > base_abs);
  assign trk_load  = tsn_en && (ph == PH_WAIT) && (now_abs >= eff_base);

  txg_cfg_regs #(
    .NQ(NQ), .NS_W(NS_W), .SEC_W(SEC_W), .ADDR_W(ADDR_W), .DATA_W(32)
  ) u_cfg (
    .clk(clk), .rst(rst), .tsn_en(tsn_en),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .commit(commit),
    .cyc_act(cyc_act), .win_st(win_st), .win_end(win_end),
    .base_sec(base_sec), .base_ns(base_ns)
  );

  txg_align_div #(.T_W(T_W), .C_W(NS_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start),
    .dividend(now_abs - base_abs), .divisor(cyc_act),
    .busy(div_busy), .done(div_done), .rem(div_rem)
  );

  txg_cycle_track #(.T_W(T_W), .C_W(NS_W)) u_trk (
    .clk(clk), .rst(rst), .load(trk_load), .load_time(eff_base),
    .run(running), .now_abs(now_abs), .cycle(cyc_act),
    .pos(pos), .bnd(bnd)
  );

  // arming sequence: capture, align a past base, wait for it, run
  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_OFF;
      cap_now  <= '0;
      cyc_cap  <= '0;
      eff_base <= '0;
      strict_q <= 1'b0;
    end else if (!tsn_en) begin
      ph <= PH_OFF;
    end else begin
      unique case (ph)
        PH_OFF: begin
          strict_q <= (base_sec != '0) || (base_ns != '0);
          cap_now  <= now_abs;
          cyc_cap  <= cyc_act;
          if (now_abs > base_abs) begin
            ph <= PH_ALIGN;
          end else begin
            eff_base <= base_abs;
            ph       <= PH_WAIT;
          end
        end
        PH_ALIGN: begin
          if (div_done) begin
            eff_base <= cap_now - T_W'(div_rem) + T_W'(cyc_cap);
            ph       <= PH_WAIT;
          end
        end
        PH_WAIT: if (now_abs >= eff_base) ph <= PH_RUN;
        default: ph <= PH_RUN;
      endcase
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    txg_gate_eval #(.T_W(T_W), .NS_W(NS_W), .LEN_W(LEN_W)) u_gate (
      .clk(clk), .rst(rst),
      .bypass(!tsn_en), .active(running), .strict(strict_q),
      .pos(pos), .cycle(cyc_act),
      .win_st(win_st[q]), .win_end(win_end[q]),
      .len(head_len[q*LEN_W +: LEN_W]),
      .gate(gate_open[q]), .may(may_send[q])
    );
  end

  // R1: disabled schedule leaves every queue free
  a_r1_bypass_open: assert property (@(posedge clk) disable iff (rst)
    !tsn_en |=> ((&gate_open) && (&may_send)));

  // R3: armed but not yet running means all gates shut
  a_r3_closed_until_base: assert property (@(posedge clk) disable iff (rst)
    (tsn_en && ph != PH_RUN) |=> (gate_open == '0) && (may_send == '0));

  // R5: an aligned base lies strictly after the captured time
  a_r5_eff_after_now: assert property (@(posedge clk) disable iff (rst)
    (tsn_en && ph == PH_ALIGN && div_done) |=> (eff_base > cap_now));

  // R9: live schedule frozen inside a running cycle
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (tsn_en && ph == PH_RUN && !bnd) |=>
      ($stable(cyc_act) && $stable(win_st) && $stable(win_end)));

  // R11: divider is never restarted while it is working
  a_r11_div_single: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !div_start);
endmodule

// File: tb/txgate_sched_bench.sv
module txgate_sched_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tsn_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] now_sec = 32'd1;
  logic [29:0] now_ns = '0;
  logic [63:0] head_len;
  logic [3:0]  gate_open, may_send;

  int unsigned lens [4];
  int          n_run = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  typedef struct {
    logic [3:0] g;
    logic [3:0] m;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;

  // bench model of the schedule
  bit                m_on = 1'b0;
  bit                m_strict = 1'b0;
  longint unsigned   m_eff = 0;
  longint unsigned   m_cyc = 1000000000;
  longint unsigned   m_st  [4];
  longint unsigned   m_end [4];

  always #2 clk = ~clk;

  assign head_len = {lens[3][15:0], lens[2][15:0], lens[1][15:0], lens[0][15:0]};

  txgate_sched u_txgate_sched (
    .clk(clk), .rst(rst), .tsn_en(tsn_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .now_sec(now_sec), .now_ns(now_ns), .head_len(head_len),
    .gate_open(gate_open), .may_send(may_send)
  );

  function automatic longint unsigned align(longint unsigned t, longint unsigned b,
                                            longint unsigned c);
    if (t > b) return b + ((t - b) / c + 1) * c;
    return b;
  endfunction

  function automatic void model(input longint unsigned t,
                                output logic [3:0] g, output logic [3:0] m);
    longint unsigned pos, fin;
    bit o;
    g = '0;
    m = '0;
    if (!m_on) begin
      g = '1;
      m = '1;
      return;
    end
    if (t < m_eff) return;
    pos = (t - m_eff) % m_cyc;
    for (int q = 0; q < 4; q++) begin
      fin  = pos + 64'(lens[q]);
      o    = (m_st[q] <= pos) && (pos < m_end[q]) && (pos < m_cyc);
      g[q] = o;
      m[q] = m_strict ? (o && fin <= m_end[q] && fin <= m_cyc) : o;
    end
  endfunction

  // monitor: compares one queued expectation per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      n_run++;
      if (gate_open !== mon_e.g || may_send !== mon_e.m) begin
        n_fail++;
        $display("FAIL %s: gate=%b may=%b expected gate=%b may=%b",
                 mon_e.tag, gate_open, may_send, mon_e.g, mon_e.m);
      end
    end
  end

  task automatic wr(input int a, input longint unsigned d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 4'(a);
    cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic set_time(input int unsigned s, input int unsigned ns);
    @(negedge clk);
    now_sec = s;
    now_ns  = 30'(ns);
  endtask

  task automatic set_lens(input int unsigned a, input int unsigned b,
                          input int unsigned c, input int unsigned d);
    lens[0] = a; lens[1] = b; lens[2] = c; lens[3] = d;
  endtask

  // driver: pushes the expected result, monitor checks after one more edge
  task automatic chk(input int settle, input string tag);
    logic [3:0] g, m;
    exp_t e;
    repeat (settle) @(negedge clk);
    #1;
    model(longint'(now_sec) * 64'd1000000000 + longint'(now_ns), g, m);
    e.g = g; e.m = m; e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic load_windows();
    wr(0, 1000);
    wr(4, 0);   wr(5, 400);
    wr(6, 300); wr(7, 700);
    wr(8, 600); wr(9, 1000);
    m_cyc = 1000;
    m_st[0] = 0;   m_end[0] = 400;
    m_st[1] = 300; m_end[1] = 700;
    m_st[2] = 600; m_end[2] = 1000;
  endtask

  task automatic enable(input longint unsigned base);
    @(negedge clk);
    tsn_en   = 1'b1;
    m_on     = 1'b1;
    m_strict = (base != 0);
    m_eff    = align(longint'(now_sec) * 64'd1000000000 + longint'(now_ns), base, m_cyc);
    repeat (80) @(negedge clk);
  endtask

  task automatic disable_sched();
    @(negedge clk);
    tsn_en = 1'b0;
    m_on   = 1'b0;
    m_cyc  = 1000000000;
    for (int q = 0; q < 4; q++) begin
      m_st[q]  = 0;
      m_end[q] = 1000000000;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int q = 0; q < 4; q++) begin
      m_st[q]  = 0;
      m_end[q] = 1000000000;
    end
    set_lens(60000, 60000, 60000, 60000);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk(2, "R1 after reset");

    // first schedule: base in the future, strict mode
    load_windows();
    wr(10, 500); wr(11, 500);
    m_st[3] = 500; m_end[3] = 500;
    wr(1, 2000); wr(2, 5);
    set_time(5, 0);
    enable(64'd5000002000);
    chk(3, "R3 armed before base");
    set_time(5, 1999);
    chk(3, "R4 one ns before base");
    set_lens(50, 50, 50, 50);
    set_time(5, 2000);
    chk(3, "R4 R12 opens at base");
    set_time(5, 2350);
    chk(3, "R6 R7 overlap fits");
    set_lens(51, 50, 50, 50);
    chk(1, "R7 one ns past window end");
    set_lens(50, 50, 50, 50);
    set_time(5, 2650);
    chk(3, "R6 window end exact fit");
    set_time(5, 2950);
    chk(3, "R7 fits cycle end");
    set_lens(50, 50, 60, 50);
    chk(1, "R7 exceeds cycle end");
    set_lens(50, 50, 50, 50);
    set_time(5, 3400);
    chk(4, "R6 end edge and empty window");
    set_time(5, 3100);
    chk(4, "R6 early in cycle");
    set_time(5, 3450);
    chk(0, "R11 one clock latency");

    // mid-cycle reprogramming
    wr(10, 100); wr(11, 900);
    set_time(5, 3600);
    chk(3, "R9 held inside cycle");
    set_time(5, 4100);
    m_st[3] = 100; m_end[3] = 900;
    chk(4, "R9 applied after boundary");
    wr(0, 0);
    set_time(5, 5200);
    chk(4, "R10 zero cycle ignored");

    // disable, then base zero with restored defaults
    disable_sched();
    chk(1, "R1 disabled bypass");
    wr(1, 0); wr(2, 0);
    set_time(7, 123);
    enable(64'd0);
    chk(3, "R3 waiting for aligned base");
    set_lens(60000, 60000, 60000, 60000);
    set_time(8, 10);
    chk(4, "R2 R8 defaults and non-strict");

    // past base aligned to next boundary
    disable_sched();
    load_windows();
    wr(1, 100); wr(2, 5);
    set_time(9, 250);
    enable(64'd5000000100);
    chk(3, "R5 aligned wait");
    set_lens(50, 50, 50, 50);
    set_time(9, 1099);
    chk(3, "R5 just before aligned base");
    set_time(9, 1100);
    chk(3, "R5 opens at aligned base");
    set_lens(50, 50, 50, 600);
    set_time(9, 1450);
    chk(3, "R7 R2 default window strict cycle end");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule